// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Shifter

This block converts a parallel word into a serial bit stream and runs entirely on one fast system clock. A word is captured from the parallel inputs while the active-low load input is held low. After load is released, each rising edge of a derived shift clock moves the word one stage toward the last stage, and stage 0 takes the serial input. The last stage is driven out twice: once as is and once inverted. Several instances can be chained, with each true serial output wired to the next instance's serial input, to build a longer converter.

The shift clock is formed as the OR of two control inputs: a shift clock and an active-low clock enable. Either input can act as the clock while the other is held low. Neither input clocks any flop. All four control inputs (load, shift clock, enable and serial data) pass through a shared synchronizer of `SYNC_STAGES` flops. An edge tracker then watches the OR value. It has two states: `ECK_HI` (the OR was 1 last cycle) and `ECK_LO` (the OR was 0 last cycle). The transition `ECK_LO -> ECK_HI` is a rising edge, and it produces a one-cycle shift pulse unless load is active. The transitions `ECK_HI -> ECK_LO`, `ECK_HI -> ECK_HI` and `ECK_LO -> ECK_LO` produce no pulse. The register itself chooses one of three modes each cycle: `MD_LOAD` (load active), `MD_SHIFT` (shift pulse) or `MD_HOLD` (otherwise).

Top module: `piso_chain_shifter`

## Requirements
- R1: While `rst` is high, all stages clear to zero regardless of the other inputs, so `ser_out` is 0 and `ser_out_n` is 1; the edge tracker starts in `ECK_HI`.
- R2: While `load_n` is low, the stages follow `par_in` every cycle, and `ser_out` tracks `par_in[WIDTH-1]`; shift-clock and enable activity during this time causes no shift.
- R3: While `load_n` is high, each rising edge of (`sclk` OR `sclk_en_n`) moves stage i into stage i+1, and stage 0 takes `ser_in`.
- R4: While `sclk_en_n` is high, toggling `sclk` causes no shift and the contents are kept.
- R5: Raising or lowering `sclk_en_n` while `sclk` is high causes no shift.
- R6: With `sclk` held low, a rising edge of `sclk_en_n` acts as a shift clock.
- R7: Releasing `load_n` while both `sclk` and `sclk_en_n` are low does not shift; the first shift comes with the next rising edge of the OR.
- R8: `ser_out_n` is always the inverse of `ser_out`.
- R9: When two instances are chained (the first's `ser_out` drives the second's `ser_in`, and all controls are shared), 2*WIDTH shift edges bring out the second word and then the first, each MSB first.
- R10: After a load, `ser_out` presents bit WIDTH-1 first and then bits WIDTH-2 down to 0 on successive shift edges.
- R11: A rising edge on `sclk` changes `ser_out` on exactly the (SYNC_STAGES+1)-th rising `clk` edge after the input change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | WIDTH | Parallel word; bit WIDTH-1 is shifted out first |
| ser_in | input | 1 | Serial data into stage 0 |
| load_n | input | 1 | Active-low level load |
| sclk | input | 1 | Shift clock input (sampled) |
| sclk_en_n | input | 1 | Active-low clock enable, ORed with `sclk` |
| ser_out | output | 1 | Last stage, true |
| ser_out_n | output | 1 | Last stage, inverted |

## Verification
On every cycle, the embedded properties check the register's step rule: a load copies the parallel word, a shift pulse moves every stage by one and takes the serial bit, and every other cycle leaves the contents unchanged. They also check that no shift pulse appears while the enable is held high and that shift pulses never come two in a row. Only the bench scenarios can show what the port-level orderings do: an enable released while the clock is high, the enable acting as the clock, load released with both clock inputs low, the exact synchronizer latency, and the word order coming out of a chained pair. The bench sweeps every 8-bit word through load, MSB-first readout and serial refill.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic {
        ECK_LO = 1'b0,
        ECK_HI = 1'b1
    } eclk_state_t;

    typedef enum logic [1:0] {
        MD_HOLD  = 2'd0,
        MD_SHIFT = 2'd1,
        MD_LOAD  = 2'd2
    } stage_mode_t;

    localparam int CTL_BITS  = 4;
    localparam int CTL_LOADN = 0;
    localparam int CTL_SCLK  = 1;
    localparam int CTL_ENN   = 2;
    localparam int CTL_SER   = 3;

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int                WIDTH   = 4,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[LAST];

endmodule

// File: rtl/piso_edge.sv
module piso_edge
    import piso_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic en_n_s,
    input  logic ld_n_s,
    output logic shift_pulse
);
    eclk_state_t state, state_nxt;
    logic        eff;

    assign eff = sclk_s | en_n_s;

    always_ff @(posedge clk) begin
        if (rst) state <= ECK_HI;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ECK_LO:  state_nxt = eff ? ECK_HI : ECK_LO;
            ECK_HI:  state_nxt = eff ? ECK_HI : ECK_LO;
            default: state_nxt = ECK_HI;
        endcase
    end

    always_comb begin
        shift_pulse = 1'b0;
        unique case (state)
            ECK_LO:  shift_pulse = eff & ld_n_s;
            ECK_HI:  shift_pulse = 1'b0;
            default: shift_pulse = 1'b0;
        endcase
    end

    // R3: one rising edge yields exactly one shift pulse
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (!rst && shift_pulse) |=> !shift_pulse);

    // R4: enable held high across two cycles leaves no room for a shift
    p_enable_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (!rst && en_n_s && $past(en_n_s)) |-> !shift_pulse);

    // R2: load active suppresses any shift pulse
    p_load_masks_r2: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ld_n_s) |-> !shift_pulse);

endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_n,
    input  logic             shift,
    input  logic             ser_bit,
    input  logic [WIDTH-1:0] par,
    output logic [WIDTH-1:0] q
);
    localparam int MSB = WIDTH - 1;

    stage_mode_t      mode;
    logic [WIDTH-1:0] shin;
    logic [WIDTH-1:0] nxt;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_src
            if (g == 0) begin : g_head
                assign shin[g] = ser_bit;
            end else begin : g_body
                assign shin[g] = q[g-1];
            end
        end
    endgenerate

    always_comb begin
        if (!ld_n)      mode = MD_LOAD;
        else if (shift) mode = MD_SHIFT;
        else            mode = MD_HOLD;
    end

    always_comb begin
        nxt = q;
        unique case (mode)
            MD_LOAD:  nxt = par;
            MD_SHIFT: nxt = shin;
            MD_HOLD:  nxt = q;
            default:  nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R2: load copies the parallel word
    p_load_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ld_n) |=> q == $past(par));

    // R3: shift moves every stage up by one and stage 0 takes the serial bit
    p_shift_move_r3: assert property (@(posedge clk) disable iff (rst)
        (!rst && ld_n && shift) |=> q == {$past(q[MSB-1:0]), $past(ser_bit)});

    // R4: with no load and no shift the contents stay
    p_hold_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (!rst && ld_n && !shift) |=> $stable(q));

endmodule

// File: rtl/piso_chain_shifter.sv
module piso_chain_shifter
    import piso_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             load_n,
    input  logic             sclk,
    input  logic             sclk_en_n,
    output logic             ser_out,
    output logic             ser_out_n
);
    localparam int                  MSB      = WIDTH - 1;
    localparam logic [CTL_BITS-1:0] CTL_RST  = 4'b0011;

    logic [CTL_BITS-1:0] ctl_raw, ctl_s;
    logic                shift_pulse;
    logic [WIDTH-1:0]    stages;

    always_comb begin
        ctl_raw            = '0;
        ctl_raw[CTL_LOADN] = load_n;
        ctl_raw[CTL_SCLK]  = sclk;
        ctl_raw[CTL_ENN]   = sclk_en_n;
        ctl_raw[CTL_SER]   = ser_in;
    end

    piso_sync #(
        .WIDTH   (CTL_BITS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    piso_edge u_edge (
        .clk         (clk),
        .rst         (rst),
        .sclk_s      (ctl_s[CTL_SCLK]),
        .en_n_s      (ctl_s[CTL_ENN]),
        .ld_n_s      (ctl_s[CTL_LOADN]),
        .shift_pulse (shift_pulse)
    );

    piso_stages #(
        .WIDTH (WIDTH)
    ) u_stages (
        .clk     (clk),
        .rst     (rst),
        .ld_n    (ctl_s[CTL_LOADN]),
        .shift   (shift_pulse),
        .ser_bit (ctl_s[CTL_SER]),
        .par     (par_in),
        .q       (stages)
    );

    assign ser_out   = stages[MSB];
    assign ser_out_n = ~stages[MSB];

endmodule

// File: tb/piso_chain_shifter_bench.sv
module piso_chain_shifter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int SETTLE     = 4;
    localparam int WD_CYCLES  = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] par = '0;
    logic         ser_in = 1'b0;
    logic         load_n = 1'b1;
    logic         sclk = 1'b0;
    logic         en_n = 1'b0;
    logic         ser_out, ser_out_n;

    logic [W-1:0] par_hi = 8'h3C;
    logic [W-1:0] par_lo = 8'hC5;
    logic         mid_out, mid_out_n, end_out, end_out_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    piso_chain_shifter u_piso_chain_shifter (
        .clk(clk), .rst(rst), .par_in(par), .ser_in(ser_in), .load_n(load_n),
        .sclk(sclk), .sclk_en_n(en_n), .ser_out(ser_out), .ser_out_n(ser_out_n));

    piso_chain_shifter u_piso_chain_shifter_hi (
        .clk(clk), .rst(rst), .par_in(par_hi), .ser_in(1'b0), .load_n(load_n),
        .sclk(sclk), .sclk_en_n(en_n), .ser_out(mid_out), .ser_out_n(mid_out_n));

    piso_chain_shifter u_piso_chain_shifter_lo (
        .clk(clk), .rst(rst), .par_in(par_lo), .ser_in(mid_out), .load_n(load_n),
        .sclk(sclk), .sclk_en_n(en_n), .ser_out(end_out), .ser_out_n(end_out_n));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_sclk();
        sclk = 1'b0; settle();
        sclk = 1'b1; settle();
    endtask

    task automatic load_word(input logic [W-1:0] v);
        par = v; load_n = 1'b0; settle();
        load_n = 1'b1; settle();
    endtask

    // reads W bits MSB first, feeding 'feed' MSB first into stage 0
    task automatic read_word(output logic [W-1:0] w, input logic [W-1:0] feed);
        for (int i = 0; i < W; i++) begin
            w[W-1-i] = ser_out;
            if (ser_out_n !== ~ser_out) check("R8 complement", {31'd0, ser_out_n}, {31'd0, ~ser_out});
            ser_in = feed[W-1-i];
            pulse_sclk();
        end
        ser_in = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] got, fed;
        logic [2*W-1:0] chain;

        // R1: reset dominates an active load
        par = 8'hFF; load_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 ser_out in reset", {31'd0, ser_out}, 32'd0);
        check("R1 ser_out_n in reset", {31'd0, ser_out_n}, 32'd1);
        check("R1 chain out in reset", {31'd0, end_out}, 32'd0);
        load_n = 1'b1; rst = 1'b0; settle();
        check("R1 cleared after release", {31'd0, ser_out}, 32'd0);

        // R10, R3, R8: sweep every word, read it back, then refill serially
        for (int v = 0; v < (1 << W); v++) begin
            logic [W-1:0] word;
            word = W'(v);
            fed  = word ^ 8'h5A;
            load_word(word);
            if (ser_out !== word[W-1]) check("R2 out tracks top bit", {31'd0, ser_out}, {31'd0, word[W-1]});
            read_word(got, fed);
            if (got !== word) check("R10 MSB-first readout", {24'd0, got}, {24'd0, word});
            read_word(got, 8'h00);
            if (got !== fed) check("R3 serial refill", {24'd0, got}, {24'd0, fed});
        end
        check("R10 sweep completed", 32'd1, 32'd1);

        // R2: clock activity during load is ignored; output follows top bit
        par = 8'hB4; load_n = 1'b0; settle();
        for (int i = 0; i < 3; i++) pulse_sclk();
        check("R2 follows D top during load", {31'd0, ser_out}, 32'd1);
        par = 8'h4B; settle();
        check("R2 tracks new word", {31'd0, ser_out}, 32'd0);
        load_n = 1'b1; settle();
        read_word(got, 8'h00);
        check("R2 no shift during load", {24'd0, got}, 32'h4B);

        // R7: load released with both clock inputs low
        sclk = 1'b0; en_n = 1'b0; par = 8'h96; load_n = 1'b0; settle();
        load_n = 1'b1; settle();
        check("R7 no shift on release", {31'd0, ser_out}, 32'd1);
        read_word(got, 8'h00);
        check("R7 word intact", {24'd0, got}, 32'h96);

        // R4: enable high blocks clock edges
        load_word(8'hC3);
        en_n = 1'b1; settle();
        for (int i = 0; i < 4; i++) pulse_sclk();
        en_n = 1'b0; settle();
        read_word(got, 8'h00);
        check("R4 enable-high hold", {24'd0, got}, 32'hC3);

        // R5: enable toggled while clock high
        load_word(8'h71);
        sclk = 1'b1; settle();
        en_n = 1'b1; settle();
        en_n = 1'b0; settle();
        en_n = 1'b1; settle();
        en_n = 1'b0; settle();
        read_word(got, 8'h00);
        check("R5 enable release with clock high", {24'd0, got}, 32'h71);

        // R6: enable acts as clock while sclk low
        sclk = 1'b0; en_n = 1'b1; par = 8'hA6; load_n = 1'b0; settle();
        load_n = 1'b1; settle();
        en_n = 1'b0; settle(); en_n = 1'b1; settle();
        check("R6 first enable edge", {31'd0, ser_out}, 32'd0);
        en_n = 1'b0; settle(); en_n = 1'b1; settle();
        check("R6 second enable edge", {31'd0, ser_out}, 32'd1);
        en_n = 1'b0; settle();
        read_word(got, 8'h00);
        check("R6 word after two shifts", {24'd0, got}, 32'h98);

        // R11: exact latency from sclk rise to output change
        sclk = 1'b0; par = 8'h80; load_n = 1'b0; settle();
        load_n = 1'b1; settle();
        sclk = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 unchanged before latency", {31'd0, ser_out}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        check("R11 changed at latency", {31'd0, ser_out}, 32'd0);
        settle();

        // R9: two chained instances give a 2W-bit stream, later word first
        sclk = 1'b0; load_n = 1'b0; settle();
        load_n = 1'b1; settle();
        for (int i = 0; i < 2*W; i++) begin
            chain[2*W-1-i] = end_out;
            pulse_sclk();
        end
        check("R9 chained stream", {16'd0, chain}, {16'd0, par_lo, par_hi});
        check("R8 chain complement", {31'd0, end_out_n}, {31'd0, ~end_out});

        done = 1'b1;
        finish_run();
    end

endmodule